// File: doc/BRIEF.md
# Delay Count Coarse/Fine Splitter

This block takes a linear delay count, expressed in interpolator steps, and turns it into the fields that a delay line programs: a coarse pointer counted in half-clock steps, a fine interpolator code for what is left over, and two deadband control bits. The deadband bits depend on where the leftover code lands relative to an early and a late threshold. When a count is too large for the fields, a range-error flag is raised.

A training engine or sequencer pulses a write strobe with a new count. One clock later the block shows the stored fields together with a one-cycle valid pulse. Between strobes the fields hold their values. A readback output continuously rebuilds the linear count from the stored coarse and fine fields. The half-clock step size, the count width and both thresholds are parameters. A power-of-two step is handled with a shift, and any other step with a constant divider.

Top module: `delay_code_splitter`

## Requirements
- R1: While reset is asserted and right after it, every field output, the error flag, the valid flag and the readback are zero.
- R2: The coarse output (4 bits) equals floor(count / STEP) modulo 16, with STEP = 32 by default.
- R3: The residual is count minus coarse × STEP. The fine output (6 bits) is that residual modulo 64.
- R4: The deadband enable is 1 exactly when the residual is below EARLY_TH (default 4) or above LATE_TH (default 28).
- R5: The early-select is 1 exactly when the residual is below EARLY_TH, so whenever early-select is 1 the deadband enable is also 1.
- R6: The range error is 1 exactly when the residual exceeds 63. This happens when the quotient does not fit in the 4-bit coarse field.
- R7: The readback equals coarse × STEP + fine, computed from the stored fields.
- R8: The outputs take the new values at the first rising edge at which the strobe is sampled high, and valid is high during the cycle that follows that edge. At an edge where the strobe is low, valid drops and all fields hold, whatever the count input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for a new count |
| delayIn | input | CNT_W (10) | Linear delay count |
| coarseOut | output | 4 | Half-clock pointer field |
| fineOut | output | 6 | Fine interpolator code |
| dbEnOut | output | 1 | Deadband enable |
| earlySelOut | output | 1 | Deadband early select |
| rangeErrOut | output | 1 | Residual exceeds the fine field |
| validOut | output | 1 | One-cycle pulse after a strobe |
| readbackOut | output | RB_W (10) | Linear count rebuilt from the stored fields |

## Verification
Every count of the 10-bit input is written once. This sweep covers residuals on both sides of each threshold, the exact threshold values, and counts whose quotient wraps the 4-bit coarse field, which is where the range error, the wrapped fine code and the shortened readback diverge from the plain split. A run of back-to-back strobes shows that valid stays high and the fields follow each count. Changing the count without a strobe must leave every field and the readback unchanged, which separates a register that loads only on the strobe from one that loads on every clock.

// File: rtl/delay_code_splitter_pkg.sv
package delay_code_splitter_pkg;
  localparam int COARSE_W = 4;
  localparam int FINE_W   = 6;
  localparam int FINE_MAX = (1 << FINE_W) - 1;

  typedef struct packed {
    logic load;
  } ctrlStrobes_t;
endpackage

// File: rtl/delay_code_splitter_ctrl.sv
module delay_code_splitter_ctrl
  import delay_code_splitter_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrEn,
  output ctrlStrobes_t strobes,
  output logic         validOut
);
  logic validQ;

  always_comb strobes.load = wrEn;

  always_ff @(posedge clk) begin
    if (!rst_n) validQ <= 1'b0;
    else        validQ <= wrEn;
  end

  assign validOut = validQ;

  // R8: valid follows a strobe, and only a strobe
  a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> validOut);
  a_r8_no_valid_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> !validOut);
endmodule

// File: rtl/delay_code_splitter_calc.sv
module delay_code_splitter_calc
  import delay_code_splitter_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int STEP     = 32,
  parameter int EARLY_TH = 4,
  parameter int LATE_TH  = 28
) (
  input  logic [CNT_W-1:0]    countIn,
  output logic [COARSE_W-1:0] coarse,
  output logic [FINE_W-1:0]   fine,
  output logic                dbEn,
  output logic                earlySel,
  output logic                rangeErr
);
  localparam logic [CNT_W-1:0] STEP_V  = CNT_W'(STEP);
  localparam logic [CNT_W-1:0] EARLY_V = CNT_W'(EARLY_TH);
  localparam logic [CNT_W-1:0] LATE_V  = CNT_W'(LATE_TH);
  localparam logic [CNT_W-1:0] FMAX_V  = CNT_W'(FINE_MAX);
  localparam bit   STEP_POW2 = (STEP & (STEP - 1)) == 0;
  localparam int   STEP_LOG  = $clog2(STEP);

  logic [CNT_W-1:0] quotient;
  logic [CNT_W-1:0] coarseWide;
  logic [CNT_W-1:0] residual;

  generate
    if (STEP_POW2) begin : g_shift
      assign quotient = countIn >> STEP_LOG;
    end else begin : g_divide
      assign quotient = countIn / STEP_V;
    end
  endgenerate

  always_comb begin
    coarse     = quotient[COARSE_W-1:0];
    coarseWide = CNT_W'(coarse);
    residual   = countIn - coarseWide * STEP_V;
    fine       = residual[FINE_W-1:0];
    earlySel   = residual < EARLY_V;
    dbEn       = (residual < EARLY_V) || (residual > LATE_V);
    rangeErr   = residual > FMAX_V;
  end
endmodule

// File: rtl/delay_code_splitter_dp.sv
module delay_code_splitter_dp
  import delay_code_splitter_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int STEP     = 32,
  parameter int EARLY_TH = 4,
  parameter int LATE_TH  = 28,
  parameter int RB_W     = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobes_t        strobes,
  input  logic                validIn,
  input  logic [CNT_W-1:0]    delayIn,
  output logic [COARSE_W-1:0] coarseOut,
  output logic [FINE_W-1:0]   fineOut,
  output logic                dbEnOut,
  output logic                earlySelOut,
  output logic                rangeErrOut,
  output logic [RB_W-1:0]     readbackOut
);
  logic [COARSE_W-1:0] coarseNxt;
  logic [FINE_W-1:0]   fineNxt;
  logic dbEnNxt, earlyNxt, errNxt;

  delay_code_splitter_calc #(
    .CNT_W(CNT_W), .STEP(STEP), .EARLY_TH(EARLY_TH), .LATE_TH(LATE_TH)
  ) calc_i (
    .countIn (delayIn),
    .coarse  (coarseNxt),
    .fine    (fineNxt),
    .dbEn    (dbEnNxt),
    .earlySel(earlyNxt),
    .rangeErr(errNxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarseOut   <= '0;
      fineOut     <= '0;
      dbEnOut     <= 1'b0;
      earlySelOut <= 1'b0;
      rangeErrOut <= 1'b0;
    end else if (strobes.load) begin
      coarseOut   <= coarseNxt;
      fineOut     <= fineNxt;
      dbEnOut     <= dbEnNxt;
      earlySelOut <= earlyNxt;
      rangeErrOut <= errNxt;
    end
  end

  assign readbackOut = RB_W'(coarseOut) * RB_W'(STEP) + RB_W'(fineOut);

  // R8: fields hold when no strobe is sampled
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.load |=> ($stable(coarseOut) && $stable(fineOut) && $stable(dbEnOut)
                       && $stable(earlySelOut) && $stable(rangeErrOut)));
  // R5: early-select implies deadband enable
  a_r5_early_in_db: assert property (@(posedge clk) disable iff (!rst_n)
    earlySelOut |-> dbEnOut);

  generate
    if (STEP <= FINE_MAX + 1) begin : g_bound
      // R6: without a range error the fine code stays inside one step
      a_r6_fine_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (validIn && !rangeErrOut) |-> (int'(fineOut) < STEP));
    end
  endgenerate
endmodule

// File: rtl/delay_code_splitter.sv
module delay_code_splitter
  import delay_code_splitter_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int STEP     = 32,
  parameter int EARLY_TH = 4,
  parameter int LATE_TH  = 28,
  localparam int RB_W    = $clog2((1 << COARSE_W) * STEP + (1 << FINE_W))
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [CNT_W-1:0]    delayIn,
  output logic [COARSE_W-1:0] coarseOut,
  output logic [FINE_W-1:0]   fineOut,
  output logic                dbEnOut,
  output logic                earlySelOut,
  output logic                rangeErrOut,
  output logic                validOut,
  output logic [RB_W-1:0]     readbackOut
);
  ctrlStrobes_t strobes;

  delay_code_splitter_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrEn    (wrEn),
    .strobes (strobes),
    .validOut(validOut)
  );

  delay_code_splitter_dp #(
    .CNT_W(CNT_W), .STEP(STEP), .EARLY_TH(EARLY_TH), .LATE_TH(LATE_TH), .RB_W(RB_W)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .validIn    (validOut),
    .delayIn    (delayIn),
    .coarseOut  (coarseOut),
    .fineOut    (fineOut),
    .dbEnOut    (dbEnOut),
    .earlySelOut(earlySelOut),
    .rangeErrOut(rangeErrOut),
    .readbackOut(readbackOut)
  );
endmodule

// File: tb/delay_code_splitter_tb_top.sv
module delay_code_splitter_tb_top;
  localparam int CNT_W = 10;
  localparam int STEP  = 32;
  localparam int EARLY = 4;
  localparam int LATE  = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [CNT_W-1:0] delayIn = '0;
  logic [3:0] coarseOut;
  logic [5:0] fineOut;
  logic dbEnOut, earlySelOut, rangeErrOut, validOut;
  logic [9:0] readbackOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  delay_code_splitter dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .delayIn(delayIn),
    .coarseOut(coarseOut), .fineOut(fineOut), .dbEnOut(dbEnOut),
    .earlySelOut(earlySelOut), .rangeErrOut(rangeErrOut),
    .validOut(validOut), .readbackOut(readbackOut)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_count(int c);
    int q, c4, res;
    q   = c / STEP;
    c4  = q % 16;
    res = c - c4 * STEP;
    chk("R2 coarse", int'(coarseOut), c4);
    chk("R3 fine", int'(fineOut), res % 64);
    chk("R4 deadband", int'(dbEnOut), int'((res < EARLY) || (res > LATE)));
    chk("R5 early", int'(earlySelOut), int'(res < EARLY));
    chk("R6 range", int'(rangeErrOut), int'(res > 63));
    chk("R7 readback", int'(readbackOut), c4 * STEP + (res % 64));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 coarse", int'(coarseOut), 0);
    chk("R1 fine", int'(fineOut), 0);
    chk("R1 flags", int'({dbEnOut, earlySelOut, rangeErrOut, validOut}), 0);
    chk("R1 readback", int'(readbackOut), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(validOut), 0);

    // exhaustive sweep, one strobe per count
    for (int c = 0; c < (1 << CNT_W); c++) begin
      wrEn = 1'b1;
      delayIn = CNT_W'(c);
      @(negedge clk);
      wrEn = 1'b0;
      chk("R8 valid pulse", int'(validOut), 1);
      check_count(c);
      @(negedge clk);
      chk("R8 valid drop", int'(validOut), 0);
    end

    // back-to-back strobes
    wrEn = 1'b1;
    for (int c = 100; c < 110; c++) begin
      delayIn = CNT_W'(c);
      @(negedge clk);
      chk("R8 back-to-back valid", int'(validOut), 1);
      check_count(c);
    end
    wrEn = 1'b0;

    // count changes with no strobe: fields hold (last written was 109)
    for (int c = 500; c < 505; c++) begin
      delayIn = CNT_W'(c);
      @(negedge clk);
      chk("R8 hold valid", int'(validOut), 0);
      check_count(109);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule